// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sits in the feedback path of a frequency synthesiser. It counts input clock cycles and issues one single-cycle pulse at the end of every division period. The length of each period, the modulus, is chosen at the boundary where the period starts. A 7-bit integer ratio is combined with an 18-bit fractional ratio. A first-order delta-sigma accumulator then moves the modulus between the integer value and the integer value plus one. Over many periods the mean ratio converges to the integer part plus (fraction + 0.5) / 2^18. The extra half step means the fraction is never exactly zero.

A mode input turns the modulator off. The divider then repeats the integer modulus on every period and the accumulator is cleared. The ratio inputs and the mode input are sampled only at a period boundary, so software may change them at any time without shortening a period that is under way. Integer values too small for the counter to reload are raised to a floor of four.

Top module: `fracn_div_ctrl`

## Requirements
- R1: `fb_pulse` is high for exactly one clock, in the last cycle of each period. The number of cycles in a period equals the value shown on `cur_modulus` during that period. A new modulus appears on `cur_modulus` in the cycle after the pulse.
- R2: In fractional mode every period lasts either clamp(`int_part`) or clamp(`int_part`)+1 cycles. Starting from a cleared accumulator, the number of longer periods among the next n periods is floor(n·(2·`frac_part`+1) / 2^19).
- R3: If `dsm_en` is low at a period boundary, the next period lasts exactly clamp(`int_part`) cycles and the accumulator is cleared to zero.
- R4: The accumulator is 19 bits wide and adds 2·`frac_part`+1 at each boundary. A carry out of bit 18 makes the next modulus one larger. With `frac_part`=0x1FFFF and a cleared accumulator, the first four periods last M, M, M+1, M cycles.
- R5: Changes to `int_part`, `frac_part` or `dsm_en` during a period do not alter the length of that period. They take effect from the next boundary.
- R6: While `rst_n` is low, the accumulator is cleared, `cur_modulus` shows clamp(`int_part`) and `fb_pulse` is low. The first period after reset is released lasts clamp(`int_part`) cycles.
- R7: clamp(v) is v for v ≥ 4 and 4 otherwise. `cur_modulus` is never below 4.
- R8: When `int_part`=127 and a carry occurs, the modulus is 128. `cur_modulus` is 8 bits wide to hold this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Synchronous active-low reset |
| int_part | input | 7 | Integer division ratio |
| frac_part | input | 18 | Fractional division ratio, in units of 2^-18 (half a step is added implicitly) |
| dsm_en | input | 1 | High selects fractional (modulated) mode, low selects integer-only mode |
| fb_pulse | output | 1 | Feedback pulse in the last cycle of each period |
| cur_modulus | output | 8 | Length of the current period, in cycles |

## Verification
The assertions assume two things about the inputs. First, `int_part` and `dsm_en` are meaningful at every period boundary. Second, reset is held for at least one edge, so the counter is loaded before it runs. Because the controls may move freely, the properties compare each new modulus only with the value sampled at the boundary where it was loaded. The stimulus drives every input away from the active edge. It reaches a cleared accumulator by passing one boundary in integer mode before it counts long periods, so the count can be predicted in closed form. It also changes the ratio partway through a period, to show that the period in progress keeps its length.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Default geometry of the divider controller.
  localparam int unsigned DEF_INT_W     = 7;
  localparam int unsigned DEF_FRAC_W    = 18;
  localparam int unsigned DEF_MOD_FLOOR = 4;

  // Mode in which a period was started.
  typedef enum logic {
    MODE_INTEGER    = 1'b0,
    MODE_FRACTIONAL = 1'b1
  } fracn_mode_e;
endpackage

// File: rtl/fracn_dsm_acc.sv
module fracn_dsm_acc #(
  parameter int unsigned FRAC_W = 18,
  localparam int unsigned ACC_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              enable,
  input  logic [FRAC_W-1:0] frac_part,
  output logic              carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  // Increment carries the implied half step as a fixed-one LSB.
  function automatic logic [ACC_W:0] add_step(input logic [ACC_W-1:0] acc,
                                              input logic [FRAC_W-1:0] f);
    return {1'b0, acc} + {1'b0, f, 1'b1};
  endfunction

  assign acc_sum = add_step(acc_q, frac_part);
  assign carry   = rst_n & enable & acc_sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= enable ? acc_sum[ACC_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/fracn_mod_sel.sv
module fracn_mod_sel #(
  parameter int unsigned INT_W     = 7,
  parameter int unsigned MOD_FLOOR = 4,
  localparam int unsigned MOD_W    = INT_W + 1
) (
  input  logic [INT_W-1:0] int_part,
  input  logic             carry,
  output logic [MOD_W-1:0] next_mod
);
  logic [MOD_W-1:0] base_mod;

  function automatic logic [MOD_W-1:0] raise_to_floor(input logic [INT_W-1:0] v);
    if ({1'b0, v} < MOD_W'(MOD_FLOOR)) return MOD_W'(MOD_FLOOR);
    return {1'b0, v};
  endfunction

  generate
    if (MOD_FLOOR > 0) begin : g_floor
      assign base_mod = raise_to_floor(int_part);
    end else begin : g_plain
      assign base_mod = {1'b0, int_part};
    end
  endgenerate

  assign next_mod = base_mod + MOD_W'(carry);
endmodule

// File: rtl/fracn_period_cnt.sv
module fracn_period_cnt #(
  parameter int unsigned MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] load_mod,
  output logic             period_end,
  output logic [MOD_W-1:0] mod_q
);
  logic [MOD_W-1:0] remain_q;

  assign period_end = rst_n && (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || remain_q == '0) begin
      remain_q <= load_mod - 1'b1;
      mod_q    <= load_mod;
    end else begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int unsigned INT_W     = DEF_INT_W,
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned MOD_FLOOR = DEF_MOD_FLOOR,
  localparam int unsigned MOD_W    = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_part,
  input  logic              dsm_en,
  output logic              fb_pulse,
  output logic [MOD_W-1:0]  cur_modulus
);
  // Named internal events, visible to the bound checker.
  logic             period_end;
  logic             dsm_carry;
  logic [MOD_W-1:0] next_mod;
  fracn_mode_e      mode_now;

  assign mode_now = dsm_en ? MODE_FRACTIONAL : MODE_INTEGER;

  fracn_dsm_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (period_end),
    .enable    (mode_now == MODE_FRACTIONAL),
    .frac_part (frac_part),
    .carry     (dsm_carry)
  );

  fracn_mod_sel #(.INT_W(INT_W), .MOD_FLOOR(MOD_FLOOR)) u_sel (
    .int_part (int_part),
    .carry    (dsm_carry),
    .next_mod (next_mod)
  );

  fracn_period_cnt #(.MOD_W(MOD_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_mod   (next_mod),
    .period_end (period_end),
    .mod_q      (cur_modulus)
  );

  assign fb_pulse = period_end;
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk #(
  parameter int unsigned INT_W     = 7,
  parameter int unsigned MOD_FLOOR = 4,
  localparam int unsigned MOD_W    = INT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INT_W-1:0] int_part,
  input logic             dsm_en,
  input logic             fb_pulse,
  input logic [MOD_W-1:0] cur_modulus,
  input logic             dsm_carry
);
  logic [MOD_W:0] run_len;

  function automatic logic [MOD_W-1:0] lim(input logic [INT_W-1:0] v);
    return ({1'b0, v} < MOD_W'(MOD_FLOOR)) ? MOD_W'(MOD_FLOOR) : {1'b0, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || fb_pulse) run_len <= (MOD_W+1)'(1);
    else                    run_len <= run_len + 1'b1;
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> run_len == {1'b0, cur_modulus});

  a_r3_int_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !dsm_en) |=> cur_modulus == lim($past(int_part)));

  a_r2_mod_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && dsm_en) |=> (cur_modulus == lim($past(int_part)) ||
                              cur_modulus == lim($past(int_part)) + 1'b1));

  a_r4_carry_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && dsm_carry) |=> cur_modulus == lim($past(int_part)) + 1'b1);

  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_pulse |=> $stable(cur_modulus));

  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    cur_modulus >= MOD_W'(MOD_FLOOR));
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk #(
  .INT_W     (INT_W),
  .MOD_FLOOR (MOD_FLOOR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_part    (int_part),
  .dsm_en      (dsm_en),
  .fb_pulse    (fb_pulse),
  .cur_modulus (cur_modulus),
  .dsm_carry   (dsm_carry)
);

// File: tb/fracn_div_ctrl_tb_top.sv
module fracn_div_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  int_part;
  logic [17:0] frac_part;
  logic        dsm_en;
  logic        fb_pulse;
  logic [7:0]  cur_modulus;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_div_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_part(int_part), .frac_part(frac_part),
    .dsm_en(dsm_en), .fb_pulse(fb_pulse), .cur_modulus(cur_modulus)
  );

  function automatic int floor4(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: position within period counting up, accumulator as an integer.
  longint m_acc;
  int     m_len;
  int     m_pos;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0;
      m_len = floor4(int_part);
      m_pos = 0;
    end else if (m_pos == m_len - 1) begin
      longint total;
      int     extra;
      extra = 0;
      if (dsm_en) begin
        total = m_acc + 2 * longint'(frac_part) + 1;
        if (total >= 524288) begin extra = 1; total -= 524288; end
        m_acc = total;
      end else begin
        m_acc = 0;
      end
      m_len = floor4(int_part) + extra;
      m_pos = 0;
    end else begin
      m_pos++;
    end
  end

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(fb_pulse == (m_pos == m_len - 1), "R1 pulse vs model", fb_pulse, m_pos == m_len - 1);
      chk(cur_modulus == m_len, "R1 modulus vs model", cur_modulus, m_len);
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      summary_and_end();
    end
  end

  // Advance to the first cycle of the next period.
  task automatic to_next_period();
    while (!fb_pulse) @(negedge clk);
    @(negedge clk);
  endtask

  // Called in the first cycle of a period; returns its length.
  task automatic measure(output int len);
    len = 1;
    while (!fb_pulse) begin @(negedge clk); len++; end
    @(negedge clk);
  endtask

  // Clear accumulator via one integer-mode boundary, then enable.
  task automatic clear_then_enable(input int mint, input int mfrac);
    int_part  = 7'(mint);
    frac_part = 18'(mfrac);
    dsm_en    = 1'b0;
    to_next_period();
    to_next_period();
    dsm_en = 1'b1;
    to_next_period();
  endtask

  task automatic frac_run(input int mint, input int mfrac, input int n, output int longest);
    int carries = 0, odd = 0, len;
    longint exp_c;
    longest = 0;
    clear_then_enable(mint, mfrac);
    for (int k = 0; k < n; k++) begin
      measure(len);
      if (len > longest) longest = len;
      if (len == floor4(mint) + 1) carries++;
      else if (len != floor4(mint)) odd++;
    end
    exp_c = (longint'(n) * (2 * longint'(mfrac) + 1)) >> 19;
    chk(carries == exp_c, "R2 long-period count", carries, exp_c);
    chk(odd == 0, "R2 lengths outside M..M+1", odd, 0);
  endtask

  initial begin
    int len, longest, cnt_ok;
    rst_n = 1'b0; int_part = 7'd10; frac_part = 18'h12345; dsm_en = 1'b1;
    repeat (5) @(negedge clk);
    // R6 reset state
    chk(cur_modulus == 10, "R6 modulus in reset", cur_modulus, 10);
    chk(fb_pulse == 1'b0, "R6 pulse low in reset", fb_pulse, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    measure(len);
    chk(len == 10, "R6 first period length", len, 10);

    // R2 several patterns
    frac_run(4, 18'h1FFFF, 500, longest);
    frac_run(9, 18'h3FFFF, 300, longest);
    frac_run(20, 0, 100, longest);
    chk(longest == 20, "R2 tiny fraction gives no long period", longest, 20);
    frac_run(127, 18'h2AAAA, 100, longest);
    // R8 modulus 128
    chk(longest == 128, "R8 longest period at int 127", longest, 128);

    // R4 explicit carry sequence from cleared accumulator
    clear_then_enable(5, 18'h1FFFF);
    measure(len); chk(len == 5, "R4 period 1", len, 5);
    measure(len); chk(len == 5, "R4 period 2", len, 5);
    measure(len); chk(len == 6, "R4 period 3", len, 6);
    measure(len); chk(len == 5, "R4 period 4", len, 5);

    // R3 integer mode, fraction present but ignored
    int_part = 7'd6; frac_part = 18'h3FFFF; dsm_en = 1'b0;
    to_next_period(); to_next_period();
    cnt_ok = 0;
    for (int k = 0; k < 20; k++) begin measure(len); if (len == 6) cnt_ok++; end
    chk(cnt_ok == 20, "R3 integer periods of 6", cnt_ok, 20);

    // R7 floor
    int_part = 7'd1;
    to_next_period(); to_next_period();
    measure(len); chk(len == 4, "R7 int 1 raised to 4", len, 4);
    int_part = 7'd0;
    to_next_period();
    measure(len); chk(len == 4, "R7 int 0 raised to 4", len, 4);
    chk(cur_modulus == 4, "R7 modulus shows 4", cur_modulus, 4);

    // R5 mid-period change
    int_part = 7'd30;
    to_next_period(); to_next_period();
    len = 1;
    repeat (4) begin @(negedge clk); len++; end
    int_part = 7'd8; dsm_en = 1'b1; frac_part = 18'h3FFFF;
    while (!fb_pulse) begin @(negedge clk); len++; end
    chk(len == 30, "R5 in-progress period kept", len, 30);
    @(negedge clk);
    chk(cur_modulus == 8, "R5 new ratio at next boundary", cur_modulus, 8);

    repeat (50) @(negedge clk);
    run_cmp = 1'b0;
    summary_and_end();
  end
endmodule